// File: doc/BRIEF.md
# Presettable Synchronous BCD Digit Counter

This block is a single decimal digit counter. On each rising clock edge it moves from 0 through 9 and wraps back to 0. A synchronous active-low clear forces the digit to zero. A synchronous active-low preset copies a four-bit value into the digit. The digit advances only when both of its count-enable inputs are high. All state bits change together on the clock edge, and nothing changes between edges.

A carry output is high while the digit shows 9 and the cascade enable is high. Wide decimal counters are built from a chain of these digits, with no extra gating. Each stage takes its cascade enable from the carry of the stage below, and a shared enable drives the parallel enable of every stage.

The six codes that are not decimal (10 to 15) can be reached through a preset. From any of them, counting leads back into the decimal range within two counting edges, through a fixed successor chain.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `rstN` is low, the digit reads 0000 and `carryOut` is low.
- R2: When `clrN` is low at a rising edge, the digit becomes 0000, whatever the levels of `enP`, `enT` and `loadN`. Clear takes priority over preset.
- R3: When `loadN` is low and `clrN` is high at a rising edge, the digit takes `dataIn`, whatever the levels of the enables. Values 10 to 15 are loaded as given.
- R4: When `clrN` and `loadN` are high and both `enP` and `enT` are high at a rising edge, a digit from 0 to 8 increases by one.
- R5: When `clrN` and `loadN` are high and either enable is low at a rising edge, the digit holds its value.
- R6: A counting edge taken while the digit is 9 returns it to 0.
- R7: `carryOut` is high exactly when `enT` is high and the digit is 9 (1001). It follows `enT` within the same cycle, without a clock edge.
- R8: Counting edges move the non-decimal codes along fixed successors: 10→11→6, 12→13→4 and 14→15→2. Any of them therefore reaches a decimal code within two counting edges.
- R9: In a two-digit chain, the tens `enT` is tied to the units `carryOut` and `enP` is shared. This chain counts from 00 to 99 and then wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset to 0 |
| clrN | input | 1 | Synchronous active-low clear |
| loadN | input | 1 | Synchronous active-low preset |
| enP | input | 1 | Parallel count enable; does not affect the carry |
| enT | input | 1 | Cascade count enable; also gates the carry |
| dataIn | input | 4 | Preset value |
| count | output | 4 | Current digit value |
| carryOut | output | 1 | Ripple carry: digit is 9 and `enT` is high |

## Verification
Clear and preset can both be requested at the same edge. So can preset and an enabled count. The bench provokes both cases by pulling `clrN` and `loadN` low together, and by asserting `loadN` while both enables are high with the digit at 9. It judges each edge against a behavioural reference model that applies the order clear, then preset, then count, then hold. The same model also covers invalid presets followed by counting edges, the combinational carry response to `enT`, and a two-digit chain run through 99.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W   = 4;
  localparam int LAST_CODE = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef struct packed {
    logic clear;
    logic load;
    logic advance;
  } digitStrobes_t;

  function automatic digit_t successor(input digit_t cur);
    digit_t nxt;
    if (cur < digit_t'(LAST_CODE))       nxt = cur + digit_t'(1);
    else if (cur == digit_t'(LAST_CODE)) nxt = '0;
    else begin
      case (cur)
        digit_t'(10): nxt = digit_t'(11);
        digit_t'(11): nxt = digit_t'(6);
        digit_t'(12): nxt = digit_t'(13);
        digit_t'(13): nxt = digit_t'(4);
        digit_t'(14): nxt = digit_t'(15);
        default:      nxt = digit_t'(2);
      endcase
    end
    return nxt;
  endfunction
endpackage

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
  import bcd_pkg::*;
(
  input  logic          clrN,
  input  logic          loadN,
  input  logic          enP,
  input  logic          enT,
  output digitStrobes_t strobes
);
  always_comb begin
    strobes         = '0;
    strobes.clear   = ~clrN;
    strobes.load    = clrN & ~loadN;
    strobes.advance = clrN & loadN & enP & enT;
  end
endmodule

// File: rtl/bcd_datapath.sv
module bcd_datapath
  import bcd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  digitStrobes_t strobes,
  input  logic          enT,
  input  digit_t        dataIn,
  output digit_t        digitQ,
  output logic          carry
);
  digit_t digitD;

  always_comb begin
    digitD = digitQ;
    if (strobes.clear)        digitD = '0;
    else if (strobes.load)    digitD = dataIn;
    else if (strobes.advance) digitD = successor(digitQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) digitQ <= '0;
    else       digitQ <= digitD;
  end

  assign carry = enT & (digitQ == digit_t'(LAST_CODE));
endmodule

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter
  import bcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clrN,
  input  logic               loadN,
  input  logic               enP,
  input  logic               enT,
  input  logic [DIGIT_W-1:0] dataIn,
  output logic [DIGIT_W-1:0] count,
  output logic               carryOut
);
  digitStrobes_t strobes;

  bcd_ctrl uCtrl (
    .clrN    (clrN),
    .loadN   (loadN),
    .enP     (enP),
    .enT     (enT),
    .strobes (strobes)
  );

  bcd_datapath uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .enT     (enT),
    .dataIn  (dataIn),
    .digitQ  (count),
    .carry   (carryOut)
  );
endmodule

// File: rtl/bcd_digit_counter_chk.sv
module bcd_digit_counter_chk
  import bcd_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               clrN,
  input logic               loadN,
  input logic               enP,
  input logic               enT,
  input logic [DIGIT_W-1:0] dataIn,
  input logic [DIGIT_W-1:0] count,
  input logic               carryOut
);
  logic counting;
  assign counting = clrN && loadN && enP && enT;

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> count == '0);

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && !loadN) |=> count == $past(dataIn));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && loadN && !(enP && enT)) |=> $stable(count));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (counting && count == DIGIT_W'(LAST_CODE)) |=> count == '0);

  // R7
  carry_needs_ent_chk: assert property (@(posedge clk) disable iff (!rstN)
    carryOut |-> (enT && count == DIGIT_W'(LAST_CODE)));

  // R8
  recover_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (counting && count > DIGIT_W'(LAST_CODE) && count[0]) |=> count <= DIGIT_W'(LAST_CODE));
endmodule

bind bcd_digit_counter bcd_digit_counter_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .clrN     (clrN),
  .loadN    (loadN),
  .enP      (enP),
  .enT      (enT),
  .dataIn   (dataIn),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/tb_bcd_digit_counter.sv
module tb_bcd_digit_counter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clrN = 1'b1, loadN = 1'b1, enP = 1'b0, enTU = 1'b0;
  logic [3:0] dataU = '0, dataT = '0;
  logic [3:0] countU, countT;
  logic carryU, carryT;
  int checks = 0;
  int errors = 0;
  int refU = 0, refT = 0;

  always #4 clk = ~clk;

  bcd_digit_counter dut (
    .clk(clk), .rstN(rstN), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enTU),
    .dataIn(dataU), .count(countU), .carryOut(carryU));

  bcd_digit_counter dutTens (
    .clk(clk), .rstN(rstN), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(carryU),
    .dataIn(dataT), .count(countT), .carryOut(carryT));

  // Successors as listed in R4, R6 and R8
  function automatic int nextOf(input int v);
    case (v)
      9: return 0;
      10: return 11;
      11: return 6;
      12: return 13;
      13: return 4;
      14: return 15;
      15: return 2;
      default: return v + 1;
    endcase
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic expCarryU;
    expCarryU = (refU == 9) && enTU;
    checkVal({tag, " units"}, int'(countU), refU);
    checkVal({tag, " tens"}, int'(countT), refT);
    checkVal({tag, " R7 carryU"}, int'(carryU), int'(expCarryU));
    checkVal({tag, " R7 carryT"}, int'(carryT), int'((refT == 9) && expCarryU));
  endtask

  task automatic tick(input string tag);
    logic cu;
    @(posedge clk);
    cu = (refU == 9) && enTU;
    if (!clrN) begin refU = 0; refT = 0; end
    else if (!loadN) begin refU = int'(dataU); refT = int'(dataT); end
    else begin
      if (enP && enTU) refU = nextOf(refU);
      if (enP && cu) refT = nextOf(refT);
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t,
                       input int du, input int dt);
    clrN = c; loadN = l; enP = p; enTU = t;
    dataU = 4'(du); dataT = 4'(dt);
  endtask

  task automatic runAll();
    @(negedge clk);
    compareAll("R1 reset");
    rstN = 1'b1;
    // sequence: clear, preset 7, count to 3, inhibit
    drive(0, 1, 1, 1, 5, 5); tick("R2 clear");
    drive(1, 0, 0, 0, 7, 0); tick("R3 preset 7");
    drive(1, 1, 1, 1, 0, 0);
    tick("R4 count 8");
    tick("R4 count 9");
    tick("R6 wrap");
    tick("R4 count 1");
    tick("R4 count 2");
    tick("R4 count 3");
    drive(1, 1, 0, 1, 0, 0); tick("R5 inhibit enP");
    drive(1, 1, 1, 0, 0, 0); tick("R5 inhibit enT");
    // carry follows enT combinationally at 9
    drive(1, 0, 0, 0, 9, 0); tick("R3 load 9");
    enTU = 1'b1; #1; compareAll("R7 enT rise");
    enTU = 1'b0; #1; compareAll("R7 enT fall");
    // same-cycle conflicts
    drive(0, 0, 1, 1, 4, 4); tick("R2 clear beats load");
    drive(1, 0, 0, 0, 9, 0); tick("R3 load 9 again");
    drive(1, 0, 1, 1, 3, 2); tick("R3 load beats count");
    // invalid codes
    for (int v = 10; v < 16; v++) begin
      drive(1, 0, 1, 0, v, 0); tick("R3 invalid load");
      drive(1, 1, 1, 1, 0, 0);
      tick("R8 recover 1");
      tick("R8 recover 2");
      checkVal("R8 decimal within two", int'(countU <= 4'd9), 1);
    end
    // two-digit chain
    drive(0, 1, 1, 1, 0, 0); tick("R9 clear chain");
    drive(1, 1, 1, 1, 0, 0);
    for (int i = 1; i <= 101; i++) begin
      tick("R9 chain");
      checkVal("R9 chain value", int'(countT) * 10 + int'(countU), i % 100);
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule